// File: doc/BRIEF.md
# Remote Reconfiguration Upgrade Controller

This block chooses which configuration image a device runs: a protected factory image that is never changed in the field, or an application image that can be replaced remotely. While the factory image runs, its user logic programs an update register with the next image's selector bit, its page address and a watchdog enable and timeout. A falling edge on the active-low internal reconfiguration request copies that register into the control register and asks an external loader to fetch the chosen image.

Once the application image is running, it leaves only on a fault: a new internal request, an external request, or expiry of the application watchdog. A failed application load leads to the same fallback. On every fallback both configuration registers return to their power-on values, a one-hot cause code is latched into a 5-bit status register, and the factory image is reloaded. The loader is modelled as a start pulse answered later by a done, error or CRC-error input.

Top module: `reconf_upgrade_ctrl`

## Requirements
- R1: After reset the controller is in factory mode, not loading, with status 5'b00000, no start pulse, and the update and control registers at power-on values: selector 0, page 0, watchdog enabled, timeout all ones.
- R2: In factory mode a write stores selector, page, watchdog enable and timeout in the update register, and the read port returns the update register.
- R3: Writes outside factory mode change no register, and an external request in factory mode starts nothing and leaves status unchanged.
- R4: A falling edge of the internal request in factory mode copies update into control and gives a one-cycle start pulse with the load target (1 = application, 0 = factory) equal to the selector and the load page equal to the copied page. Selector 0 reloads the factory image.
- R5: During an application load, CRC error sets status to 5'b00001 and a generic error to 5'b10000 (CRC wins if both). Either resets both registers to power-on values and starts a factory load.
- R6: Load done during an application load enters application mode, where the read port returns the control register.
- R7: In application mode an internal request edge (status 5'b00010) beats an external request edge (5'b00100), which beats watchdog expiry (5'b01000). Each resets both registers to power-on values and starts a factory load.
- R8: With the watchdog enabled and timeout T, expiry forces the fallback T+1 cycles after entry to application mode or after the last kick pulse, which reloads the count to T.
- R9: The watchdog never expires in factory or loading states, nor in application mode when the control register's watchdog enable is 0.
- R10: Status keeps its value until the next fault, including across successful loads.
- R11: Load done during a factory load returns the controller to factory mode, clearing the busy output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Write strobe for the update register |
| cfg_wr_app | input | 1 | Written image selector (1 = application) |
| cfg_wr_page | input | PAGE_W | Written page address |
| cfg_wr_wd_en | input | 1 | Written watchdog enable |
| cfg_wr_wd_tmo | input | WD_W | Written watchdog timeout |
| cfg_rd_app | output | 1 | Read selector (update in factory, control in application) |
| cfg_rd_page | output | PAGE_W | Read page address |
| cfg_rd_wd_en | output | 1 | Read watchdog enable |
| cfg_rd_wd_tmo | output | WD_W | Read watchdog timeout |
| reconf_req_n | input | 1 | Internal reconfiguration request, active low, edge-detected |
| ext_reconf_n | input | 1 | External reconfiguration request, active low, edge-detected |
| wd_kick | input | 1 | Watchdog reload pulse |
| load_start | output | 1 | One-cycle loader start pulse |
| load_app | output | 1 | Load target of the current load (1 = application) |
| load_page | output | PAGE_W | Page address for the loader |
| load_busy | output | 1 | A load is in progress |
| load_done | input | 1 | Loader finished successfully |
| load_err | input | 1 | Loader generic error |
| load_crc_err | input | 1 | Loader CRC error |
| status | output | 5 | One-hot cause of the last fallback |
| in_app | output | 1 | Application image is running |
| wd_expired | output | 1 | Watchdog count has reached zero while running |

## Verification
The bench builds the controller with PAGE_W = 4 and WD_W = 4, so every page value can be written and read back and every timeout from 0 to 15 can be run to expiry, with the expiry cycle predicted as T+1. The small widths also keep the kick, disabled-watchdog, error-priority and request-priority cases within a short run.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

    typedef enum logic [1:0] {
        ST_FACTORY  = 2'd0,
        ST_LOAD_APP = 2'd1,
        ST_APP      = 2'd2,
        ST_LOAD_FAC = 2'd3
    } rcu_state_e;

    localparam int STAT_W = 5;

    // One-hot fault causes, bit positions are visible at the status port
    localparam logic [STAT_W-1:0] CAUSE_NONE = 5'b00000;
    localparam logic [STAT_W-1:0] CAUSE_CRC  = 5'b00001;
    localparam logic [STAT_W-1:0] CAUSE_INT  = 5'b00010;
    localparam logic [STAT_W-1:0] CAUSE_EXT  = 5'b00100;
    localparam logic [STAT_W-1:0] CAUSE_WDOG = 5'b01000;
    localparam logic [STAT_W-1:0] CAUSE_GEN  = 5'b10000;

endpackage

// File: rtl/rcu_fall_det.sv
module rcu_fall_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_n,
    output logic [N-1:0] fall
);

    for (genvar i = 0; i < N; i++) begin : g_ch
        logic prev_q;
        logic prev_d;

        always_comb begin
            prev_d = lvl_n[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b1;
            else        prev_q <= prev_d;
        end

        assign fall[i] = prev_q & ~lvl_n[i];
    end

endmodule

// File: rtl/rcu_wdog.sv
module rcu_wdog #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (run && cnt_q != '0)
            cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '1;
        else        cnt_q <= cnt_d;
    end

    // Expiry does not depend on load, so the controller may gate kicks on it
    assign expire = run && (cnt_q == '0);

    // R8: a running, non-reloaded counter steps down by exactly one
    a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

    // R8: a reload takes the programmed timeout
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/reconf_upgrade_ctrl.sv
module reconf_upgrade_ctrl
    import rcu_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int WD_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_wr_app,
    input  logic [PAGE_W-1:0] cfg_wr_page,
    input  logic              cfg_wr_wd_en,
    input  logic [WD_W-1:0]   cfg_wr_wd_tmo,
    output logic              cfg_rd_app,
    output logic [PAGE_W-1:0] cfg_rd_page,
    output logic              cfg_rd_wd_en,
    output logic [WD_W-1:0]   cfg_rd_wd_tmo,
    input  logic              reconf_req_n,
    input  logic              ext_reconf_n,
    input  logic              wd_kick,
    output logic              load_start,
    output logic              load_app,
    output logic [PAGE_W-1:0] load_page,
    output logic              load_busy,
    input  logic              load_done,
    input  logic              load_err,
    input  logic              load_crc_err,
    output logic [4:0]        status,
    output logic              in_app,
    output logic              wd_expired
);

    localparam int REQ_N   = 2;
    localparam int REQ_INT = 0;
    localparam int REQ_EXT = 1;

    typedef struct packed {
        logic              app;
        logic [PAGE_W-1:0] page;
        logic              wd_en;
        logic [WD_W-1:0]   tmo;
    } cfg_t;

    localparam cfg_t CFG_POR = '{app: 1'b0, page: '0, wd_en: 1'b1, tmo: '1};

    typedef struct packed {
        rcu_state_e        st;
        cfg_t              upd;
        cfg_t              ctl;
        logic [STAT_W-1:0] status;
        logic              start;
        logic              start_app;
    } ctrl_t;

    localparam ctrl_t CTRL_POR = '{
        st: ST_FACTORY, upd: CFG_POR, ctl: CFG_POR,
        status: CAUSE_NONE, start: 1'b0, start_app: 1'b0
    };

    ctrl_t             q;
    ctrl_t             d;
    logic [REQ_N-1:0]  req_fall;
    logic              wd_load;
    logic              wd_run;
    logic              wd_exp;
    logic [STAT_W-1:0] app_cause;
    cfg_t              wr_cfg;

    rcu_fall_det #(.N(REQ_N)) u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_n ({ext_reconf_n, reconf_req_n}),
        .fall  (req_fall)
    );

    assign wd_run = (q.st == ST_APP) && q.ctl.wd_en;

    rcu_wdog #(.W(WD_W)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (wd_run),
        .load     (wd_load),
        .load_val (q.ctl.tmo),
        .expire   (wd_exp)
    );

    always_comb begin
        wr_cfg = '{app: cfg_wr_app, page: cfg_wr_page,
                   wd_en: cfg_wr_wd_en, tmo: cfg_wr_wd_tmo};

        // Runtime fault priority: internal, external, watchdog
        if (req_fall[REQ_INT])      app_cause = CAUSE_INT;
        else if (req_fall[REQ_EXT]) app_cause = CAUSE_EXT;
        else if (wd_exp)            app_cause = CAUSE_WDOG;
        else                        app_cause = CAUSE_NONE;
    end

    always_comb begin
        d         = q;
        d.start   = 1'b0;
        wd_load   = 1'b0;
        unique case (q.st)
            ST_FACTORY: begin
                if (cfg_wr)
                    d.upd = wr_cfg;
                if (req_fall[REQ_INT]) begin
                    d.ctl       = q.upd;
                    d.start     = 1'b1;
                    d.start_app = q.upd.app;
                    d.st        = q.upd.app ? ST_LOAD_APP : ST_LOAD_FAC;
                end
            end
            ST_LOAD_APP: begin
                if (load_crc_err || load_err) begin
                    d.status    = load_crc_err ? CAUSE_CRC : CAUSE_GEN;
                    d.upd       = CFG_POR;
                    d.ctl       = CFG_POR;
                    d.start     = 1'b1;
                    d.start_app = 1'b0;
                    d.st        = ST_LOAD_FAC;
                end else if (load_done) begin
                    d.st    = ST_APP;
                    wd_load = 1'b1;
                end
            end
            ST_APP: begin
                if (app_cause != CAUSE_NONE) begin
                    d.status    = app_cause;
                    d.upd       = CFG_POR;
                    d.ctl       = CFG_POR;
                    d.start     = 1'b1;
                    d.start_app = 1'b0;
                    d.st        = ST_LOAD_FAC;
                end else if (wd_kick) begin
                    wd_load = 1'b1;
                end
            end
            ST_LOAD_FAC: begin
                if (load_done)
                    d.st = ST_FACTORY;
            end
            default: d = CTRL_POR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTRL_POR;
        else        q <= d;
    end

    always_comb begin
        if (q.st == ST_APP) begin
            cfg_rd_app    = q.ctl.app;
            cfg_rd_page   = q.ctl.page;
            cfg_rd_wd_en  = q.ctl.wd_en;
            cfg_rd_wd_tmo = q.ctl.tmo;
        end else begin
            cfg_rd_app    = q.upd.app;
            cfg_rd_page   = q.upd.page;
            cfg_rd_wd_en  = q.upd.wd_en;
            cfg_rd_wd_tmo = q.upd.tmo;
        end
    end

    assign load_start = q.start;
    assign load_app   = q.start_app;
    assign load_page  = q.ctl.page;
    assign load_busy  = (q.st == ST_LOAD_APP) || (q.st == ST_LOAD_FAC);
    assign status     = q.status;
    assign in_app     = (q.st == ST_APP);
    assign wd_expired = wd_exp;

    // R4: the loader start is a single-cycle pulse
    a_r4_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        load_start |=> !load_start);

    // R9: no expiry outside application mode
    a_r9_wd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_app |-> !wd_expired);

    // R5: a failed application load heads for the factory image with a cause
    a_r5_err_path: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LOAD_APP && (load_crc_err || load_err)) |=>
        (q.st == ST_LOAD_FAC && load_start && !load_app && status != CAUSE_NONE));

    // R7: leaving application mode leaves both registers at power-on values
    a_r7_fault_por: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_app) |-> (q.ctl == CFG_POR && q.upd == CFG_POR));

    // R7: the status code is always one-hot or clear
    a_r7_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status));

    // R10: no fault can be recorded from the factory side
    a_r10_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FACTORY || q.st == ST_LOAD_FAC) |=> $stable(status));

endmodule

// File: tb/sim_reconf_upgrade_ctrl.sv
module sim_reconf_upgrade_ctrl;

    localparam int CLK_P   = 10;
    localparam int PAGE_W  = 4;
    localparam int WD_W    = 4;
    localparam int LAT     = 3;
    localparam int WDOG_LIM = 50000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic              cfg_wr_app = 1'b0;
    logic [PAGE_W-1:0] cfg_wr_page = '0;
    logic              cfg_wr_wd_en = 1'b0;
    logic [WD_W-1:0]   cfg_wr_wd_tmo = '0;
    logic              cfg_rd_app;
    logic [PAGE_W-1:0] cfg_rd_page;
    logic              cfg_rd_wd_en;
    logic [WD_W-1:0]   cfg_rd_wd_tmo;
    logic              reconf_req_n = 1'b1;
    logic              ext_reconf_n = 1'b1;
    logic              wd_kick = 1'b0;
    logic              load_start;
    logic              load_app;
    logic [PAGE_W-1:0] load_page;
    logic              load_busy;
    logic              load_done = 1'b0;
    logic              load_err = 1'b0;
    logic              load_crc_err = 1'b0;
    logic [4:0]        status;
    logic              in_app;
    logic              wd_expired;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #(CLK_P/2) clk = ~clk;

    reconf_upgrade_ctrl #(.PAGE_W(PAGE_W), .WD_W(WD_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_wr_app(cfg_wr_app), .cfg_wr_page(cfg_wr_page),
        .cfg_wr_wd_en(cfg_wr_wd_en), .cfg_wr_wd_tmo(cfg_wr_wd_tmo),
        .cfg_rd_app(cfg_rd_app), .cfg_rd_page(cfg_rd_page),
        .cfg_rd_wd_en(cfg_rd_wd_en), .cfg_rd_wd_tmo(cfg_rd_wd_tmo),
        .reconf_req_n(reconf_req_n), .ext_reconf_n(ext_reconf_n), .wd_kick(wd_kick),
        .load_start(load_start), .load_app(load_app), .load_page(load_page),
        .load_busy(load_busy), .load_done(load_done), .load_err(load_err),
        .load_crc_err(load_crc_err), .status(status), .in_app(in_app),
        .wd_expired(wd_expired)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
    endtask

    // packed read port: {app, page, wd_en, tmo}
    function automatic logic [31:0] rd_word();
        return 32'({cfg_rd_app, cfg_rd_page, cfg_rd_wd_en, cfg_rd_wd_tmo});
    endfunction

    function automatic logic [31:0] mk(logic a, logic [PAGE_W-1:0] p, logic e, logic [WD_W-1:0] t);
        return 32'({a, p, e, t});
    endfunction

    localparam logic [31:0] POR_WORD = 32'({1'b0, {PAGE_W{1'b0}}, 1'b1, {WD_W{1'b1}}});

    task automatic write_upd(logic a, logic [PAGE_W-1:0] p, logic e, logic [WD_W-1:0] t);
        cfg_wr = 1'b1; cfg_wr_app = a; cfg_wr_page = p; cfg_wr_wd_en = e; cfg_wr_wd_tmo = t;
        tick();
        cfg_wr = 1'b0;
    endtask

    // Program and request an application load; leaves it in the loading state
    task automatic start_load(logic [PAGE_W-1:0] p, logic e, logic [WD_W-1:0] t);
        write_upd(1'b1, p, e, t);
        chk("R2 readback", rd_word(), mk(1'b1, p, e, t));
        reconf_req_n = 1'b0;
        tick();
        reconf_req_n = 1'b1;
        chk("R4 start pulse", 32'({load_start, load_app, load_busy}), 32'b111);
        chk("R4 load page", 32'(load_page), 32'(p));
        tick();
        chk("R4 pulse ends", 32'(load_start), 32'd0);
        repeat (LAT - 2) tick();
    endtask

    task automatic finish_app(logic [PAGE_W-1:0] p, logic e, logic [WD_W-1:0] t);
        load_done = 1'b1;
        tick();
        load_done = 1'b0;
        chk("R6 in app", 32'({in_app, load_busy}), 32'b10);
        chk("R6 read control", rd_word(), mk(1'b1, p, e, t));
    endtask

    // Check fallback outcome then complete the factory load
    task automatic check_fallback(string req, logic [4:0] code);
        chk(req, 32'(status), 32'(code));
        chk(req, 32'({in_app, load_start, load_app, load_busy}), 32'b0101);
        chk(req, rd_word(), POR_WORD);
        load_done = 1'b1;
        tick();
        load_done = 1'b0;
        chk("R11 back to factory", 32'({load_busy, in_app}), 32'd0);
    endtask

    initial begin
        while (cyc < WDOG_LIM) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        chk("R1 reset flags", 32'({in_app, load_busy, load_start, wd_expired}), 32'd0);
        chk("R1 reset status", 32'(status), 32'd0);
        chk("R1 reset regs", rd_word(), POR_WORD);
        rst_n = 1'b1;
        tick();
        chk("R1 after release", rd_word(), POR_WORD);

        // R2: sweep pages and fields through the update register
        for (int p = 0; p < (1 << PAGE_W); p++) begin
            write_upd(p[0], PAGE_W'(p), p[1], WD_W'(15 - p));
            chk("R2 write sweep", rd_word(), mk(p[0], PAGE_W'(p), p[1], WD_W'(15 - p)));
        end

        // R3: external request in factory mode is ignored
        ext_reconf_n = 1'b0;
        tick();
        ext_reconf_n = 1'b1;
        tick();
        chk("R3 ext in factory", 32'({load_start, load_busy, in_app}), 32'd0);
        chk("R3 ext status", 32'(status), 32'd0);

        // R4: selector 0 reloads the factory image
        write_upd(1'b0, 4'd9, 1'b1, 4'd3);
        reconf_req_n = 1'b0;
        tick();
        reconf_req_n = 1'b1;
        chk("R4 factory target", 32'({load_start, load_app, load_busy}), 32'b101);
        chk("R4 factory page", 32'(load_page), 32'd9);
        load_done = 1'b1;
        tick();
        load_done = 1'b0;
        chk("R11 reload done", 32'({load_busy, in_app}), 32'd0);
        chk("R10 status untouched", 32'(status), 32'd0);

        // R5: CRC error
        start_load(4'd5, 1'b1, 4'd4);
        load_crc_err = 1'b1;
        tick();
        load_crc_err = 1'b0;
        check_fallback("R5 crc", 5'b00001);

        // R10: status survives a successful load
        start_load(4'd6, 1'b0, 4'd0);
        finish_app(4'd6, 1'b0, 4'd0);
        chk("R10 status kept in app", 32'(status), 32'h1);
        // R3: writes in application mode are ignored
        write_upd(1'b0, 4'd1, 1'b1, 4'd1);
        chk("R3 write in app", rd_word(), mk(1'b1, 4'd6, 1'b0, 4'd0));
        // R9: disabled watchdog with timeout 0 never fires
        for (int k = 0; k < 40; k++) begin
            tick();
            chk("R9 disabled wdog", 32'({in_app, wd_expired}), 32'b10);
        end
        // R7: external request alone
        ext_reconf_n = 1'b0;
        tick();
        ext_reconf_n = 1'b1;
        check_fallback("R7 external", 5'b00100);

        // R5: generic error, and CRC wins over generic
        start_load(4'd2, 1'b1, 4'd7);
        load_err = 1'b1;
        tick();
        load_err = 1'b0;
        check_fallback("R5 generic", 5'b10000);
        start_load(4'd3, 1'b1, 4'd7);
        load_err = 1'b1; load_crc_err = 1'b1;
        tick();
        load_err = 1'b0; load_crc_err = 1'b0;
        check_fallback("R5 crc priority", 5'b00001);

        // R7: internal beats external
        start_load(4'd4, 1'b0, 4'd0);
        finish_app(4'd4, 1'b0, 4'd0);
        reconf_req_n = 1'b0; ext_reconf_n = 1'b0;
        tick();
        reconf_req_n = 1'b1; ext_reconf_n = 1'b1;
        check_fallback("R7 internal priority", 5'b00010);

        // R7: external beats a simultaneous watchdog expiry (T=0 expires next edge)
        start_load(4'd8, 1'b1, 4'd0);
        finish_app(4'd8, 1'b1, 4'd0);
        ext_reconf_n = 1'b0;
        tick();
        ext_reconf_n = 1'b1;
        check_fallback("R7 ext over wdog", 5'b00100);

        // R8: expiry cycle for every timeout
        for (int t = 0; t < (1 << WD_W); t++) begin
            int k;
            start_load(PAGE_W'(t), 1'b1, WD_W'(t));
            finish_app(PAGE_W'(t), 1'b1, WD_W'(t));
            k = 0;
            while (in_app && k < 40) begin
                tick();
                k++;
            end
            chk("R8 expiry cycle", 32'(k), 32'(t + 1));
            check_fallback("R7 wdog cause", 5'b01000);
        end

        // R8: kick reloads the count
        start_load(4'd11, 1'b1, 4'd6);
        finish_app(4'd11, 1'b1, 4'd6);
        repeat (4) tick();
        wd_kick = 1'b1;
        tick();
        wd_kick = 1'b0;
        begin
            int k;
            k = 0;
            while (in_app && k < 40) begin
                tick();
                k++;
            end
            chk("R8 kick reload", 32'(k), 32'd7);
        end
        check_fallback("R8 wdog after kick", 5'b01000);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule